// File: doc/BRIEF.md
# External Interrupt Trigger and Pending Controller

This block watches thirty-two asynchronous interrupt pins, arranged as four groups of eight. Each pin is brought into the clock domain by a two-stage synchroniser. It is then compared against a per-pin trigger code: low level, high level, falling edge, rising edge or either edge. A hit sets a sticky pending bit that software clears by writing a one to it. A per-pin mask bit decides whether a pending pin reaches the interrupt outputs.

Each pin of the lower sixteen drives its own registered output line. The upper sixteen pins share one combined registered line, which a handler demultiplexes by reading the pending and mask registers of the two upper groups. Software reaches trigger codes, mask bits, pending bits and a bank of plain filter-setting words through a single-cycle write port and a registered read port.

Top module: `eirq_ctrl`

## Requirements
- R1: The register windows start at byte offsets 0x000 (trigger codes), 0x080 (filter words), 0x100 (mask) and 0x140 (pending). Each window holds one word per group at a 4-byte stride. Any other address reads 0, and a write to it changes nothing.
- R2: Pin p of group g uses bits [4*p+2 : 4*p] of trigger word g. Bit 4*p+3 is never stored and always reads 0.
- R3: Trigger code 0 sets pending while the synchronised pin is low. Code 1 sets it while the pin is high. Code 2 sets it on a fall, code 3 on a rise and code 4 on either. A pin change made between two edges sets pending at the third edge that follows.
- R4: Trigger codes 5, 6 and 7 never set the pending bit.
- R5: In a level mode, pending is set again on every cycle the level stays active, so a clear has no lasting effect until the pin goes inactive.
- R6: Writing 1 to a bit of pending word g (bits 7:0) clears that pin's pending bit. Writing 0 leaves it unchanged. A trigger hit in the same cycle wins over the clear.
- R7: A mask bit of 1 blocks the pin from the outputs while its pending bit still latches. A mask bit of 0 lets the pin through.
- R8: Output line k (k = 0..15) is high one cycle after pin k is both pending and unmasked.
- R9: The combined line is high one cycle after any of pins 16..31 is both pending and unmasked.
- R10: Reset is synchronous and active high. It clears trigger codes, filter words, pending bits, outputs and synchronisers, and sets every mask bit to 1.
- R11: The filter words are 32-bit storage that reads back exactly what was written and has no effect on detection.
- R12: Read data for the address presented in one cycle appears on the read port after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 32 | Asynchronous interrupt pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 9 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_direct_o | output | 16 | One line per pin 0..15 |
| irq_comb_o | output | 1 | Combined line for pins 16..31 |

## Verification
The bench builds the block with its default parameters: four groups of eight pins, two of which drive direct lines. This places both the direct outputs and the shared line under test in one build, with a behavioural model compared on every clock. Directed sequences cover each trigger code on chosen pins, including a disabled code. They also cover the re-set of a level-mode pin after a clear, a masked upper pin that latches and then appears on the shared line when unmasked, and accesses to an unmapped address.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam logic [2:0] TRIG_LOW  = 3'd0;
  localparam logic [2:0] TRIG_HIGH = 3'd1;
  localparam logic [2:0] TRIG_FALL = 3'd2;
  localparam logic [2:0] TRIG_RISE = 3'd3;
  localparam logic [2:0] TRIG_BOTH = 3'd4;

  localparam int CODE_W  = 3;
  localparam int FIELD_W = 4;

  localparam int CFG_BASE  = 'h000;
  localparam int FLT_BASE  = 'h080;
  localparam int MASK_BASE = 'h100;
  localparam int PEND_BASE = 'h140;
  localparam int WORD_STRIDE = 4;
endpackage

// File: rtl/eirq_pin_sync.sv
module eirq_pin_sync #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] cur_o,
  output logic [NUM_PINS-1:0] prev_o
);
  logic [NUM_PINS-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign cur_o  = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/eirq_trig_detect.sv
module eirq_trig_detect
  import eirq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS*CODE_W-1:0] cfg_i,
  input  logic [NUM_PINS-1:0]        cur_i,
  input  logic [NUM_PINS-1:0]        prev_i,
  output logic [NUM_PINS-1:0]        hit_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [CODE_W-1:0] code;
    assign code = cfg_i[i*CODE_W +: CODE_W];
    always_comb begin
      case (code)
        TRIG_LOW:  hit_o[i] = ~cur_i[i];
        TRIG_HIGH: hit_o[i] = cur_i[i];
        TRIG_FALL: hit_o[i] = prev_i[i] & ~cur_i[i];
        TRIG_RISE: hit_o[i] = cur_i[i] & ~prev_i[i];
        TRIG_BOTH: hit_o[i] = cur_i[i] ^ prev_i[i];
        default:   hit_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/eirq_regfile.sv
module eirq_regfile
  import eirq_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 8,
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  input  logic [NUM_GROUPS*GROUP_W-1:0] hit_i,
  output logic [NUM_GROUPS*GROUP_W*CODE_W-1:0] cfg_o,
  output logic [NUM_GROUPS*GROUP_W-1:0] mask_o,
  output logic [NUM_GROUPS*GROUP_W-1:0] pend_o
);
  localparam int NUM_PINS = NUM_GROUPS * GROUP_W;

  logic [NUM_PINS*CODE_W-1:0] cfg_q;
  logic [DATA_W-1:0]          flt_q [NUM_GROUPS];
  logic [NUM_PINS-1:0]        mask_q, pend_q, clr_vec;
  logic [DATA_W-1:0]          rd_d;
  logic [NUM_GROUPS-1:0]      sel_cfg, sel_flt, sel_mask, sel_pend;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    assign sel_cfg[g]  = (addr_i == ADDR_W'(CFG_BASE  + g*WORD_STRIDE));
    assign sel_flt[g]  = (addr_i == ADDR_W'(FLT_BASE  + g*WORD_STRIDE));
    assign sel_mask[g] = (addr_i == ADDR_W'(MASK_BASE + g*WORD_STRIDE));
    assign sel_pend[g] = (addr_i == ADDR_W'(PEND_BASE + g*WORD_STRIDE));
    assign clr_vec[g*GROUP_W +: GROUP_W] =
      (we_i && sel_pend[g]) ? wdata_i[GROUP_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      mask_q <= '1;
      pend_q <= '0;
      for (int g = 0; g < NUM_GROUPS; g++) flt_q[g] <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | hit_i;
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (we_i && sel_cfg[g])
          for (int p = 0; p < GROUP_W; p++)
            cfg_q[(g*GROUP_W+p)*CODE_W +: CODE_W] <= wdata_i[p*FIELD_W +: CODE_W];
        if (we_i && sel_flt[g])  flt_q[g] <= wdata_i;
        if (we_i && sel_mask[g]) mask_q[g*GROUP_W +: GROUP_W] <= wdata_i[GROUP_W-1:0];
      end
    end
  end

  always_comb begin
    rd_d = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (sel_cfg[g])
        for (int p = 0; p < GROUP_W; p++)
          rd_d[p*FIELD_W +: CODE_W] = cfg_q[(g*GROUP_W+p)*CODE_W +: CODE_W];
      if (sel_flt[g])  rd_d = flt_q[g];
      if (sel_mask[g]) rd_d[GROUP_W-1:0] = mask_q[g*GROUP_W +: GROUP_W];
      if (sel_pend[g]) rd_d[GROUP_W-1:0] = pend_q[g*GROUP_W +: GROUP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_d;
  end

  assign cfg_o  = cfg_q;
  assign mask_o = mask_q;
  assign pend_o = pend_q;

  assert_mask_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    assert_disabled_code_R4: assert property (@(posedge clk) disable iff (rst)
      (!pend_q[i] && (cfg_q[i*CODE_W +: CODE_W] > TRIG_BOTH)) |=> !pend_q[i]);
    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[i] && !hit_i[i]) |=> !pend_q[i]);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !clr_vec[i]) |=> pend_q[i]);
  end
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
#(
  parameter int NUM_GROUPS    = 4,
  parameter int GROUP_W       = 8,
  parameter int DIRECT_GROUPS = 2,
  parameter int ADDR_W        = 9,
  parameter int DATA_W        = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_GROUPS*GROUP_W-1:0]       pins_i,
  input  logic                                reg_we_i,
  input  logic [ADDR_W-1:0]                   reg_addr_i,
  input  logic [DATA_W-1:0]                   reg_wdata_i,
  output logic [DATA_W-1:0]                   reg_rdata_o,
  output logic [DIRECT_GROUPS*GROUP_W-1:0]    irq_direct_o,
  output logic                                irq_comb_o
);
  localparam int NUM_PINS    = NUM_GROUPS * GROUP_W;
  localparam int DIRECT_PINS = DIRECT_GROUPS * GROUP_W;

  logic [NUM_PINS-1:0]        cur, prev, hit, mask, pend, live;
  logic [NUM_PINS*CODE_W-1:0] cfg;

  eirq_pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .pins_i(pins_i), .cur_o(cur), .prev_o(prev));

  eirq_trig_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .cfg_i(cfg), .cur_i(cur), .prev_i(prev), .hit_o(hit));

  eirq_regfile #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W),
                 .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .hit_i(hit),
    .cfg_o(cfg), .mask_o(mask), .pend_o(pend));

  assign live = pend & ~mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_direct_o <= '0;
      irq_comb_o   <= 1'b0;
    end else begin
      irq_direct_o <= live[DIRECT_PINS-1:0];
      irq_comb_o   <= |live[NUM_PINS-1:DIRECT_PINS];
    end
  end

  assert_comb_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq_comb_o |-> $past(|(pend[NUM_PINS-1:DIRECT_PINS] & ~mask[NUM_PINS-1:DIRECT_PINS])));

  for (genvar k = 0; k < DIRECT_PINS; k++) begin : g_dchk
    assert_direct_masked_R7: assert property (@(posedge clk) disable iff (rst)
      $past(mask[k]) |-> !irq_direct_o[k]);
    assert_direct_follow_R8: assert property (@(posedge clk) disable iff (rst)
      $past(pend[k] && !mask[k]) |-> irq_direct_o[k]);
  end
endmodule

// File: tb/eirq_ctrl_tb_top.sv
`timescale 1ns/1ps
module eirq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        we = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] irq_dir;
  logic        irq_comb;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  eirq_ctrl dut_i (
    .clk(clk), .rst(rst), .pins_i(pins), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_direct_o(irq_dir),
    .irq_comb_o(irq_comb));

  // Behavioural reference model
  bit        m_s1[32], m_s2[32], m_pv[32], m_mask[32], m_pend[32];
  bit [2:0]  m_cfg[32];
  bit [31:0] m_flt[4];
  bit [15:0] m_dir;
  bit        m_comb;
  bit [31:0] m_rd;

  function automatic bit trig(bit [2:0] c, bit now, bit was);
    if (c == 0) return !now;
    if (c == 1) return now;
    if (c == 2) return was && !now;
    if (c == 3) return now && !was;
    if (c == 4) return now != was;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit hits[32];
    int w, g;
    if (rst) begin
      for (int i = 0; i < 32; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0; m_mask[i] = 1;
        m_pend[i] = 0; m_cfg[i] = 0;
      end
      for (int j = 0; j < 4; j++) m_flt[j] = 0;
      m_dir = 0; m_comb = 0; m_rd = 0;
    end else begin
      for (int i = 0; i < 32; i++) hits[i] = trig(m_cfg[i], m_s2[i], m_pv[i]);
      m_comb = 0;
      for (int i = 0; i < 32; i++) begin
        if (i < 16) m_dir[i] = m_pend[i] && !m_mask[i];
        else if (m_pend[i] && !m_mask[i]) m_comb = 1;
      end
      w = int'(addr); m_rd = 0; g = -1;
      if (w % 4 == 0) g = (w % 128) / 4;
      if (w < 16 && g >= 0) begin
        for (int p = 0; p < 8; p++) m_rd[p*4 +: 3] = m_cfg[g*8+p];
        if (we) for (int p = 0; p < 8; p++) m_cfg[g*8+p] = wdata[p*4 +: 3];
      end else if (w >= 128 && w < 144 && g >= 0) begin
        m_rd = m_flt[g];
        if (we) m_flt[g] = wdata;
      end else if (w >= 256 && w < 272 && g >= 0) begin
        for (int p = 0; p < 8; p++) m_rd[p] = m_mask[g*8+p];
        if (we) for (int p = 0; p < 8; p++) m_mask[g*8+p] = wdata[p];
      end else if (w >= 320 && w < 336 && g >= 0) begin
        g = (w - 320) / 4;
        for (int p = 0; p < 8; p++) m_rd[p] = m_pend[g*8+p];
        if (we) for (int p = 0; p < 8; p++) if (wdata[p]) m_pend[g*8+p] = 0;
      end
      for (int i = 0; i < 32; i++) begin
        if (hits[i]) m_pend[i] = 1;
        m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = pins[i];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_tests++;
      if (irq_dir !== m_dir) begin
        n_fail++; $display("FAIL R8 direct lines got %h exp %h", irq_dir, m_dir);
      end
      if (irq_comb !== m_comb) begin
        n_fail++; $display("FAIL R9 combined line got %b exp %b", irq_comb, m_comb);
      end
      if (rdata !== m_rd) begin
        n_fail++; $display("FAIL R12 read data got %h exp %h", rdata, m_rd);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 9'h1FC; wdata = '0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk); we = 1'b0; addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R10 reset values
    rd(9'h100, v); chk("R10 mask g0 reset", v, 32'hFF);
    rd(9'h10C, v); chk("R10 mask g3 reset", v, 32'hFF);
    rd(9'h000, v); chk("R10 cfg g0 reset", v, 32'h0);
    rd(9'h08C, v); chk("R10 filter g3 reset", v, 32'h0);
    // R7 low-level (code 0) latches while masked; outputs stay low
    rd(9'h140, v); chk("R7 pend latched while masked", v, 32'hFF);
    chk("R7 masked direct low", {16'h0, irq_dir}, 32'h0);
    // R2 field layout: bit 3 of each nibble dropped
    for (int g = 0; g < 4; g++) wr(9'(g*4), 32'hFFFFFFFF);
    rd(9'h004, v); chk("R2 cfg nibble top bit reads 0", v, 32'h77777777);
    idle(3);
    for (int g = 0; g < 4; g++) wr(9'(9'h140 + g*4), 32'hFF);
    rd(9'h148, v); chk("R6 w1c clears group", v, 32'h0);
    // R4 disabled code: toggle pin 0 with code 7
    pins[0] = 1'b1; idle(5); pins[0] = 1'b0; idle(5);
    rd(9'h140, v); chk("R4 disabled code no pending", v, 32'h0);
    // configure group 0/1
    wr(9'h000, 32'h74273777);
    wr(9'h004, 32'h77777717);
    wr(9'h100, 32'h97);
    wr(9'h104, 32'hFD);
    // R3 rising on pin 3
    pins[3] = 1'b1; idle(5);
    chk("R3 rise pin3 -> R8 line", {31'h0, irq_dir[3]}, 32'h1);
    wr(9'h140, 32'h08); idle(3);
    chk("R6 cleared pin3 line low", {31'h0, irq_dir[3]}, 32'h0);
    pins[3] = 1'b0; idle(5);
    chk("R3 fall ignored in rise mode", {31'h0, irq_dir[3]}, 32'h0);
    // R3 falling on pin 5
    pins[5] = 1'b1; idle(5);
    chk("R3 rise ignored in fall mode", {31'h0, irq_dir[5]}, 32'h0);
    pins[5] = 1'b0; idle(5);
    chk("R3 fall pin5", {31'h0, irq_dir[5]}, 32'h1);
    // R3 both edges on pin 6
    pins[6] = 1'b1; idle(5);
    chk("R3 both rise pin6", {31'h0, irq_dir[6]}, 32'h1);
    wr(9'h140, 32'h60); idle(3);
    chk("R6 clear pins 5 6", {30'h0, irq_dir[6:5]}, 32'h0);
    pins[6] = 1'b0; idle(5);
    chk("R3 both fall pin6", {31'h0, irq_dir[6]}, 32'h1);
    // R6 write of zero leaves pending unchanged
    rd(9'h140, v);
    wr(9'h140, 32'h0);
    rd(9'h140, v2); chk("R6 write zero no effect", v2, v);
    // R5 high level on pin 9
    pins[9] = 1'b1; idle(5);
    chk("R3 high level pin9", {31'h0, irq_dir[9]}, 32'h1);
    wr(9'h144, 32'h02); idle(3);
    chk("R5 level re-sets after clear", {31'h0, irq_dir[9]}, 32'h1);
    pins[9] = 1'b0; idle(4);
    wr(9'h144, 32'h02); idle(3);
    chk("R5 clear holds once inactive", {31'h0, irq_dir[9]}, 32'h0);
    // R7 / R9 upper pin 20 (group 2, pin 4) rising, masked
    wr(9'h008, 32'h77737777);
    pins[20] = 1'b1; idle(5);
    rd(9'h148, v); chk("R7 masked upper pin latches", v, 32'h10);
    chk("R9 combined low while masked", {31'h0, irq_comb}, 32'h0);
    wr(9'h108, 32'hEF); @(negedge clk);
    chk("R7 unmask -> R9 combined high", {31'h0, irq_comb}, 32'h1);
    wr(9'h148, 32'h10); idle(2);
    chk("R9 combined low after clear", {31'h0, irq_comb}, 32'h0);
    // R11 filter storage
    wr(9'h084, 32'hDEADBEEF);
    rd(9'h084, v); chk("R11 filter readback", v, 32'hDEADBEEF);
    // R1 unmapped address
    wr(9'h0C0, 32'hFFFFFFFF);
    rd(9'h0C0, v); chk("R1 unmapped reads zero", v, 32'h0);
    rd(9'h104, v); chk("R1 mask g1 intact", v, 32'hFD);
    rd(9'h142, v); chk("R1 misaligned reads zero", v, 32'h0);
    idle(4);
    finish_run();
  end
endmodule